// File: doc/BRIEF.md
# Byte and Word Memory Lane Aligner

This block sits between a processor core and a memory that is one 16-bit word wide and has a write enable for each byte lane. The core sees a flat space of 65,536 byte locations. Peripheral registers live in that same space, so every load and store uses this one path. Each request carries a byte address, an access size, a load or store direction, a sign flag for byte loads, and the data to store. The block turns the request into a word address, lane enables and lane-placed write data. On a load it picks out the bytes it needs from the word that comes back and widens them to 16 bits.

Bytes are stored little-endian: the even address is the low lane. A word access must use an even address. A word access to an odd address does not reach memory: the block raises a one-cycle fault instead. Memory read data is combinational in the request cycle. The widened load result is registered and offered on a valid/ready response port one cycle later.

Requests use valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a load result is still waiting and `rsp_ready` is low. The response holds its value and data until it is taken, and a new request may be accepted in the same cycle that the old response is taken. Stores and faulted requests never produce a response.

Top module: `mem_lane_align`

## Requirements
- R1: For an accepted, aligned request, `mem_addr` equals `req_addr` shifted right by one: the word index.
- R2: An accepted, aligned word access drives `mem_be` = 2'b11, and on a store `mem_wdata` equals `req_wdata` unchanged.
- R3: A byte access drives exactly one lane enable. `req_addr[0]`=0 gives `mem_be`=2'b01 (bits 7:0), and `req_addr[0]`=1 gives 2'b10 (bits 15:8).
- R4: A byte store places `req_wdata[7:0]` on both lanes of `mem_wdata`, so memory changes only in the enabled lane.
- R5: A byte load with `req_signed`=0 returns the addressed lane in bits 7:0 with bits 15:8 zero.
- R6: A byte load with `req_signed`=1 copies bit 7 of the addressed lane into bits 15:8.
- R7: A word load returns the full word: the byte at the even address is in bits 7:0 and the byte at the odd address is in bits 15:8.
- R8: An accepted word access with `req_addr[0]`=1 keeps `mem_en` and `mem_we` low. It raises `fault` for exactly the next cycle, produces no response and changes no memory.
- R9: An accepted aligned load raises `rsp_valid` in the next cycle. The response holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is high.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and no memory access is issued.
- R11: `mem_we` is high only for an accepted, aligned store. An accepted store is followed by `rsp_valid` low.
- R12: After reset, `rsp_valid` and `fault` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 16 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Byte load: 1 = sign-extend, 0 = zero-extend |
| req_wdata | input | 16 | Store data (bits 7:0 for byte stores) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Word address |
| mem_be | output | 2 | Lane write enables, bit 0 = bits 7:0 |
| mem_wdata | output | 16 | Write data placed in lanes |
| mem_rdata | input | 16 | Combinational read word for the current address |
| rsp_valid | output | 1 | Load result offered |
| rsp_ready | input | 1 | Load result accepted |
| rsp_data | output | 16 | Widened load result |
| fault | output | 1 | One-cycle pulse after a misaligned word access |

## Verification
The assertions assume that the requester holds a request steady while `req_ready` is low. They also assume that `mem_rdata` reflects `mem_addr` within the request cycle, and that `rsp_ready` is a plain level the block only samples. The bench meets these assumptions. It changes inputs only on the falling clock edge. Its memory model answers reads combinationally and writes only enabled lanes on the rising edge. During the back-pressure test it holds one store request for several cycles while the earlier load result waits.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [0:0] {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  acc_size_e          size,
  output logic [WADDR_W-1:0] word_addr,
  output logic [OFF_W-1:0]   lane,
  output logic [LANES-1:0]   be,
  output logic               misaligned
);
  assign word_addr = addr[ADDR_W-1:OFF_W];
  assign lane      = addr[OFF_W-1:0];

  always_comb begin
    misaligned = (size == ACC_WORD) && (lane != '0);
    if (size == ACC_WORD) be = '1;
    else                  be = LANES'(1) << lane;
  end
endmodule

// File: rtl/store_steer.sv
module store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / LANE_W
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lane_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[g*LANE_W +: LANE_W] =
      (size == ACC_WORD) ? wdata[g*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
  end
endmodule

// File: rtl/load_extend.sv
module load_extend
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic              sign_ext,
  input  logic [OFF_W-1:0]  lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [LANE_W-1:0] picked;

  always_comb begin
    picked = rdata[lane*LANE_W +: LANE_W];
    if (size == ACC_WORD)
      result = rdata;
    else
      result = {{(DATA_W-LANE_W){sign_ext & picked[LANE_W-1]}}, picked};
  end
endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_word,
  input  logic               req_store,
  input  logic               req_signed,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               fault
);
  acc_size_e         size;
  logic [OFF_W-1:0]  lane;
  logic              misaligned;
  logic              accept;
  logic [DATA_W-1:0] load_val;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              fault_q;

  assign size = acc_size_e'(req_word);

  lane_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr       (req_addr),
    .size       (size),
    .word_addr  (mem_addr),
    .lane       (lane),
    .be         (mem_be),
    .misaligned (misaligned)
  );

  store_steer #(.DATA_W(DATA_W)) u_st (
    .size      (size),
    .wdata     (req_wdata),
    .lane_data (mem_wdata)
  );

  load_extend #(.DATA_W(DATA_W)) u_ld (
    .size     (size),
    .sign_ext (req_signed),
    .lane     (lane),
    .rdata    (mem_rdata),
    .result   (load_val)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mem_en    = accept && !misaligned;
  assign mem_we    = mem_en && req_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      fault_q     <= 1'b0;
    end else begin
      fault_q <= accept && misaligned;
      if (mem_en && !req_store) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= load_val;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign fault     = fault_q;
endmodule

// File: rtl/mem_lane_align_chk.sv
module mem_lane_align_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_word,
  input logic               req_store,
  input logic               mem_en,
  input logic               mem_we,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]   mem_be,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               fault
);
  logic acc_c;
  logic odd_c;
  assign acc_c = req_valid && req_ready;
  assign odd_c = req_addr[OFF_W-1:0] != '0;

  AST_WORD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr == req_addr[ADDR_W-1:OFF_W]); // R1
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_word) |-> mem_be == '1); // R2
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_word) |-> $countones(mem_be) == 1); // R3
  AST_MISALIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_word && odd_c) |-> (!mem_en && !mem_we)); // R8
  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_word && odd_c) |=> fault); // R8
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault || $past(acc_c && req_word && odd_c)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_store) |=> rsp_valid); // R9
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (!req_ready && !mem_en)); // R10
  AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && req_store)); // R11
  AST_STORE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_store) |=> !rsp_valid); // R11
endmodule

bind mem_lane_align mem_lane_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mem_lane_align.sv
module tb_mem_lane_align;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam int WDOG = 5000;

  typedef struct packed {
    logic        st;
    logic        wd;
    logic        sg;
    logic        flt;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic [15:0] ewd;
    logic [15:0] ersp;
  } vec_t;

  // st wd sg flt addr wdata be mem_wdata response
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,16'h0004,16'hA55A,2'b11,16'hA55A,16'h0000}, // R2 word store
    '{1'b1,1'b0,1'b0,1'b0,16'h0006,16'h1280,2'b01,16'h8080,16'h0000}, // R3 R4 even byte
    '{1'b1,1'b0,1'b0,1'b0,16'h0007,16'h34F1,2'b10,16'hF1F1,16'h0000}, // R3 R4 odd byte
    '{1'b0,1'b1,1'b0,1'b0,16'h0004,16'h0000,2'b11,16'h0000,16'hA55A}, // R7
    '{1'b0,1'b0,1'b0,1'b0,16'h0006,16'h0000,2'b01,16'h0000,16'h0080}, // R5
    '{1'b0,1'b0,1'b1,1'b0,16'h0006,16'h0000,2'b01,16'h0000,16'hFF80}, // R6
    '{1'b0,1'b0,1'b1,1'b0,16'h0007,16'h0000,2'b10,16'h0000,16'hFFF1}, // R6
    '{1'b0,1'b0,1'b0,1'b0,16'h0007,16'h0000,2'b10,16'h0000,16'h00F1}, // R5
    '{1'b0,1'b1,1'b0,1'b0,16'h0006,16'h0000,2'b11,16'h0000,16'hF180}, // R7 little-endian
    '{1'b0,1'b0,1'b0,1'b0,16'h0004,16'h0000,2'b01,16'h0000,16'h005A}, // R5
    '{1'b0,1'b0,1'b1,1'b0,16'h0005,16'h0000,2'b10,16'h0000,16'hFFA5}, // R6
    '{1'b1,1'b1,1'b0,1'b1,16'h0009,16'hDEAD,2'b11,16'h0000,16'h0000}, // R8 store
    '{1'b0,1'b1,1'b0,1'b1,16'h0009,16'h0000,2'b11,16'h0000,16'h0000}, // R8 load
    '{1'b0,1'b1,1'b0,1'b0,16'h0008,16'h0000,2'b11,16'h0000,16'h0000}, // R8 no write
    '{1'b1,1'b0,1'b0,1'b0,16'h000A,16'hFF7F,2'b01,16'h7F7F,16'h0000}, // R4
    '{1'b0,1'b0,1'b1,1'b0,16'h000A,16'h0000,2'b01,16'h0000,16'h007F}, // R6 positive
    '{1'b1,1'b1,1'b0,1'b0,16'hFFFE,16'h1234,2'b11,16'h1234,16'h0000}, // R1 top word
    '{1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,2'b10,16'h0000,16'h0012}  // R1 R5 top byte
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_store = 1'b0;
  logic        req_signed = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        mem_en;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        fault;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_align dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_store(req_store),
    .req_signed(req_signed), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fault(fault)
  );

  assign mem_rdata = model[mem_addr[3:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) model[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) model[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    check("R12 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    check("R12 fault", {15'd0, fault}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 req_ready", {15'd0, req_ready}, 16'd1);

    for (int v = 0; v < NV; v++) begin
      req_valid  = 1'b1;
      req_store  = VEC[v].st;
      req_word   = VEC[v].wd;
      req_signed = VEC[v].sg;
      req_addr   = VEC[v].addr;
      req_wdata  = VEC[v].wdata;
      #1;
      check("R8 mem_en", {15'd0, mem_en}, {15'd0, !VEC[v].flt});
      if (!VEC[v].flt) begin
        check("R1 mem_addr", {1'b0, mem_addr}, {1'b0, VEC[v].addr[15:1]});
        check("R2 R3 mem_be", {14'd0, mem_be}, {14'd0, VEC[v].be});
        if (VEC[v].st) check("R2 R4 mem_wdata", mem_wdata, VEC[v].ewd);
      end
      check("R11 mem_we", {15'd0, mem_we}, {15'd0, VEC[v].st && !VEC[v].flt});
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 fault", {15'd0, fault}, {15'd0, VEC[v].flt});
      check("R9 R11 rsp_valid", {15'd0, rsp_valid}, {15'd0, !VEC[v].st && !VEC[v].flt});
      if (!VEC[v].st && !VEC[v].flt) check("R5 R6 R7 rsp_data", rsp_data, VEC[v].ersp);
      @(negedge clk);
      check("R8 fault one cycle", {15'd0, fault}, 16'd0);
    end

    // R9 R10: response waits under back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_store = 1'b0; req_word = 1'b1; req_signed = 1'b0;
    req_addr = 16'h0004; req_wdata = '0;
    @(negedge clk);
    check("R9 rsp_valid next cycle", {15'd0, rsp_valid}, 16'd1);
    check("R9 rsp_data", rsp_data, 16'hA55A);
    req_store = 1'b1; req_wdata = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R10 req_ready low", {15'd0, req_ready}, 16'd0);
      check("R10 mem_en low", {15'd0, mem_en}, 16'd0);
      @(negedge clk);
      check("R9 held valid", {15'd0, rsp_valid}, 16'd1);
      check("R9 held data", rsp_data, 16'hA55A);
    end
    rsp_ready = 1'b1;
    #1;
    check("R10 req_ready on take", {15'd0, req_ready}, 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 no rsp after store", {15'd0, rsp_valid}, 16'd0);
    req_valid = 1'b1; req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 held store applied", rsp_data, 16'h0000);
    @(negedge clk);
    finish_run();
  end
endmodule